// File: doc/BRIEF.md
# DAC Control and Triggered Output Register

This block is the register side of an 8-bit digital-to-analog converter. Software writes a 16-bit control word and a 16-bit data word over a small synchronous register bus and can read both back. The block turns the data word into an 8-bit output code, taking either its upper or its lower byte, and holds that code in an output latch. The converter core reads the code on an internal output. A gated copy of the code and a pin-drive enable go to the pad logic.

The latch loads in one of two ways. In immediate mode it takes the code in the same edge that the data word is written. In triggered mode a data write only stores a pending value. The latch then loads on a rising edge of one of 32 event inputs, chosen by a 5-bit field of the control word.

Power modes also act on the block. In idle, a stop bit can freeze the latch. In sleep, a keep-alive bit decides whether the outputs hold the code or are forced off. There are two reset classes. A power-on reset always clears both registers. A warm reset clears them only while the soft-reset-disable bit is zero.

Top module: `dac_regif`

## Requirements
- R1: After a power-on reset both registers read 0 and code_int_o, code_pin_o and pin_oe_o are 0, whatever the soft-reset-disable bit held before.
- R2: Control bits 14 and 10 read back as 0 whatever is written. All other control bits read back as written. ref_sel_o reflects control bits 1:0.
- R3: With control bit 11 set, the code comes from data bits 15:8. With it clear, the code comes from data bits 7:0.
- R4: With control bit 8 clear and bit 15 set, a data write loads its code into the latch at the write edge. Event inputs are ignored.
- R5: With control bit 8 set, a data write only becomes pending, and a later write replaces the pending value. The latch loads the pending code at the first edge where trig_i[sel] is 1 after being 0 on the previous edge, with sel taken from control bits 6:2. Other inputs have no effect.
- R6: With control bit 15 clear, the latch clears to 0 one edge later and stays 0. Writes and events do not move it, but data writes are still stored.
- R7: With control bit 13 set and idle_i high, the latch holds through writes and events. A pending value is kept. With bit 13 clear, idle_i has no effect.
- R8: With sleep_i high and control bit 12 clear, code_int_o, code_pin_o and pin_oe_o are 0 and the latch keeps its value. With bit 12 set, the outputs keep showing the latch.
- R9: pin_oe_o is 1 only when control bits 15 and 7 are both set and the part is not powered down. When pin_oe_o is 0, code_pin_o is 0 while code_int_o still carries the code.
- R10: A warm reset (warm_rst_n low at an edge) always clears the latch and blocks bus writes. It clears both registers when control bit 9 is 0 and leaves them unchanged when bit 9 is 1.
- R11: A level held high loads the latch only once. A new rising edge is needed for the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on/brown-out reset, asynchronous active-low, released synchronously inside |
| warm_rst_n | input | 1 | Warm reset, synchronous active-low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 16 | Write value |
| rd_sel | input | 1 | Readback select: 0 control, 1 data |
| rd_data | output | 16 | Readback value |
| idle_i | input | 1 | Device is in idle |
| sleep_i | input | 1 | Device is in sleep |
| trig_i | input | 32 | Event inputs |
| code_int_o | output | 8 | Code for the converter core |
| code_pin_o | output | 8 | Code towards the pad, 0 when not driven |
| pin_oe_o | output | 1 | Pad drive enable |
| ref_sel_o | output | 2 | Reference select field |

## Verification
The bench builds the block with its defaults: 32 event inputs and an 8-bit code carried in a 16-bit data word. With these values every value of the 5-bit select field names a real input, so the bench can pick one input and pulse a neighbour to check that the neighbour is ignored. The 16-bit word also lets one data value tell the two byte positions apart. The scoreboard follows the pending-versus-loaded distinction through both reset classes and through both power modes.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  localparam int WORD_W  = 16;
  localparam int TSEL_W  = 5;
  localparam int REF_W   = 2;
  localparam logic [WORD_W-1:0] CTRL_IMPL_MASK = 16'hBBFF;

  typedef struct packed {
    logic              en;
    logic              rsvd_a;
    logic              idle_stop;
    logic              sleep_keep;
    logic              left_just;
    logic              rsvd_b;
    logic              warm_keep;
    logic              trig_mode;
    logic              pin_en;
    logic [TSEL_W-1:0] tsel;
    logic [REF_W-1:0]  refsel;
  } ctrl_t;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_t             ctrl_o,
  output logic [WORD_W-1:0] data_o
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [WORD_W-1:0] data_q, data_d;

  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    if (!warm_rst_n) begin
      if (!ctrl_q.warm_keep) begin
        ctrl_d = '0;
        data_d = '0;
      end
    end else if (wr_en) begin
      if (wr_sel) data_d = wr_data;
      else        ctrl_d = ctrl_t'(wr_data & CTRL_IMPL_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.rsvd_a == 1'b0) && (ctrl_q.rsvd_b == 1'b0));

  assert_warm_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst_n && ctrl_q.warm_keep) |=> ($stable(data_q) && $stable(ctrl_q)));

  assert_warm_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst_n && !ctrl_q.warm_keep) |=> (data_q == '0 && ctrl_q == '0));
endmodule

// File: rtl/dac_trig_detect.sv
module dac_trig_detect #(
  parameter int N_TRIG = 32,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst_n,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              edge_o
);
  localparam int SEL_SPAN = 1 << SEL_W;

  logic [N_TRIG-1:0]   trig_q;
  logic [N_TRIG-1:0]   trig_d;
  logic [SEL_SPAN-1:0] rise_ext;

  always_comb begin
    trig_d = warm_rst_n ? trig_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trig_d;
  end

  for (genvar i = 0; i < SEL_SPAN; i++) begin : g_rise
    if (i < N_TRIG) begin : g_real
      assign rise_ext[i] = trig_i[i] & ~trig_q[i];
    end else begin : g_none
      assign rise_ext[i] = 1'b0;
    end
  end

  assign edge_o = rise_ext[sel_i];

  assert_single_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && warm_rst_n) |=> (!edge_o || (sel_i != $past(sel_i))));
endmodule

// File: rtl/dac_out_latch.sv
module dac_out_latch #(
  parameter int CODE_W = 8,
  localparam int WORD_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst_n,
  input  logic              en_i,
  input  logic              active_i,
  input  logic              trig_mode_i,
  input  logic              left_just_i,
  input  logic              wr_hit_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [WORD_W-1:0] held_data_i,
  input  logic              trig_edge_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q, code_d;

  function automatic logic [CODE_W-1:0] pick(input logic [WORD_W-1:0] w, input logic left);
    return left ? w[WORD_W-1:CODE_W] : w[CODE_W-1:0];
  endfunction

  always_comb begin
    code_d = code_q;
    if (!warm_rst_n || !en_i) begin
      code_d = '0;
    end else if (active_i) begin
      if (!trig_mode_i && wr_hit_i)
        code_d = pick(wr_data_i, left_just_i);
      else if (trig_mode_i && trig_edge_i)
        code_d = pick(held_data_i, left_just_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

  assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (code_o == '0));

  assert_wait_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && warm_rst_n && trig_mode_i && !trig_edge_i) |=> $stable(code_o));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && warm_rst_n && !active_i) |=> $stable(code_o));

  assert_warm_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst_n |=> (code_o == '0));
endmodule

// File: rtl/dac_regif.sv
module dac_regif
  import dac_regif_pkg::*;
#(
  parameter int N_TRIG = 32,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [15:0]       wr_data,
  input  logic              rd_sel,
  output logic [15:0]       rd_data,
  input  logic              idle_i,
  input  logic              sleep_i,
  input  logic [N_TRIG-1:0] trig_i,
  output logic [CODE_W-1:0] code_int_o,
  output logic [CODE_W-1:0] code_pin_o,
  output logic              pin_oe_o,
  output logic [1:0]        ref_sel_o
);
  logic              rst_n;
  ctrl_t             ctrl;
  logic [WORD_W-1:0] data_q;
  logic              trig_edge;
  logic [CODE_W-1:0] code_q;
  logic              active, pwr_down, data_hit;

  dac_rst_sync u_rst (.clk(clk), .arst_n(por_rst_n), .rst_n_o(rst_n));

  dac_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_o(ctrl), .data_o(data_q)
  );

  dac_trig_detect #(.N_TRIG(N_TRIG), .SEL_W(TSEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
    .trig_i(trig_i), .sel_i(ctrl.tsel), .edge_o(trig_edge)
  );

  always_comb begin
    active   = ctrl.en & ~(idle_i & ctrl.idle_stop);
    pwr_down = sleep_i & ~ctrl.sleep_keep;
    data_hit = wr_en & wr_sel & warm_rst_n;
  end

  dac_out_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
    .en_i(ctrl.en), .active_i(active), .trig_mode_i(ctrl.trig_mode),
    .left_just_i(ctrl.left_just), .wr_hit_i(data_hit),
    .wr_data_i(wr_data), .held_data_i(data_q),
    .trig_edge_i(trig_edge), .code_o(code_q)
  );

  always_comb begin
    pin_oe_o   = ctrl.en & ctrl.pin_en & ~pwr_down;
    code_int_o = pwr_down ? '0 : code_q;
    code_pin_o = pin_oe_o ? code_q : '0;
    ref_sel_o  = ctrl.refsel;
    rd_data    = rd_sel ? data_q : WORD_W'(ctrl);
  end

  assert_rd_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rd_data[14] == 1'b0 && rd_data[10] == 1'b0));

  assert_sleep_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !rd_data[12] && !rd_sel) |-> (!pin_oe_o && code_int_o == '0));

  assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe_o |-> (code_pin_o == '0));
endmodule

// File: tb/dac_regif_tb_top.sv
module dac_regif_tb_top;
  logic        clk = 1'b0;
  logic        por_rst_n, warm_rst_n, wr_en, wr_sel, rd_sel, idle_i, sleep_i;
  logic [15:0] wr_data, rd_data;
  logic [31:0] trig_i;
  logic [7:0]  code_int_o, code_pin_o;
  logic        pin_oe_o;
  logic [1:0]  ref_sel_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit         is_rd;
    logic [15:0] e_rd;
    logic [7:0]  e_int;
    logic [7:0]  e_pin;
    logic        e_oe;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #10 clk = ~clk;

  dac_regif dut_i (
    .clk(clk), .por_rst_n(por_rst_n), .warm_rst_n(warm_rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .idle_i(idle_i), .sleep_i(sleep_i),
    .trig_i(trig_i), .code_int_o(code_int_o), .code_pin_o(code_pin_o),
    .pin_oe_o(pin_oe_o), .ref_sel_o(ref_sel_o)
  );

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.is_rd) begin
          if (rd_data !== it.e_rd) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected %h", it.tag, rd_data, it.e_rd);
          end
        end else if (code_int_o !== it.e_int || code_pin_o !== it.e_pin || pin_oe_o !== it.e_oe) begin
          errors++;
          $display("FAIL %s: int=%h pin=%h oe=%b expected int=%h pin=%h oe=%b",
                   it.tag, code_int_o, code_pin_o, pin_oe_o, it.e_int, it.e_pin, it.e_oe);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic exp_out(input logic [7:0] ci, input logic [7:0] cp, input logic oe, input string tag);
    item_t it;
    it.is_rd = 1'b0; it.e_rd = '0; it.e_int = ci; it.e_pin = cp; it.e_oe = oe; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic exp_rd(input bit sel, input logic [15:0] v, input string tag);
    item_t it;
    rd_sel = sel;
    it.is_rd = 1'b1; it.e_rd = v; it.e_int = '0; it.e_pin = '0; it.e_oe = 1'b0; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic por();
    por_rst_n = 1'b0;
    repeat (3) step();
    por_rst_n = 1'b1;
    repeat (3) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    por_rst_n = 1'b0; warm_rst_n = 1'b1; wr_en = 1'b0; wr_sel = 1'b0;
    wr_data = '0; rd_sel = 1'b0; idle_i = 1'b0; sleep_i = 1'b0; trig_i = '0;
    por();
    // R1 reset state
    exp_out(8'h00, 8'h00, 1'b0, "R1 outputs after power-on");
    exp_rd(1'b0, 16'h0000, "R1 control after power-on");
    exp_rd(1'b1, 16'h0000, "R1 data after power-on");

    // R2 reserved bits
    wr(1'b0, 16'hFFFF);
    exp_rd(1'b0, 16'hBBFF, "R2 control readback");
    if (ref_sel_o !== 2'b11) begin errors++; $display("FAIL R2: ref_sel=%b expected 11", ref_sel_o); end
    checks++;

    // R4 / R3 / R9 immediate, right justified, pin driven
    wr(1'b0, 16'h8080);
    wr(1'b1, 16'h12A5);
    exp_out(8'hA5, 8'hA5, 1'b1, "R4 R3 immediate right-justified load");
    wr(1'b0, 16'h8880);
    exp_out(8'hA5, 8'hA5, 1'b1, "R4 format change alone does not load");
    wr(1'b1, 16'h3C00);
    exp_out(8'h3C, 8'h3C, 1'b1, "R3 left-justified load");
    trig_i = 32'hFFFF_FFFF; step(); trig_i = '0; step();
    exp_out(8'h3C, 8'h3C, 1'b1, "R4 events ignored in immediate mode");

    // R5 triggered mode, select 5, pin off
    wr(1'b0, 16'h8114);
    exp_out(8'h3C, 8'h00, 1'b0, "R9 internal only when pin disabled");
    wr(1'b1, 16'h0077);
    wr(1'b1, 16'h0088);
    exp_out(8'h3C, 8'h00, 1'b0, "R5 write pending");
    trig_i[4] = 1'b1; step();
    exp_out(8'h3C, 8'h00, 1'b0, "R5 unselected input ignored");
    trig_i[5] = 1'b1; step();
    exp_out(8'h88, 8'h00, 1'b0, "R5 selected edge loads latest pending");
    wr(1'b1, 16'h0099);
    repeat (3) step();
    exp_out(8'h88, 8'h00, 1'b0, "R11 held level loads once");
    trig_i = '0; step(); trig_i[5] = 1'b1; step();
    exp_out(8'h99, 8'h00, 1'b0, "R11 new edge loads");

    // R7 idle stop
    wr(1'b0, 16'hA114);
    trig_i = '0; step();
    idle_i = 1'b1;
    wr(1'b1, 16'h0011);
    trig_i[5] = 1'b1; step();
    exp_out(8'h99, 8'h00, 1'b0, "R7 idle stop freezes latch");
    trig_i = '0; step(); idle_i = 1'b0; step();
    trig_i[5] = 1'b1; step();
    exp_out(8'h11, 8'h00, 1'b0, "R7 pending kept through idle");
    wr(1'b0, 16'h8114);
    idle_i = 1'b1;
    wr(1'b1, 16'h0022);
    trig_i = '0; step(); trig_i[5] = 1'b1; step();
    exp_out(8'h22, 8'h00, 1'b0, "R7 idle ignored without stop bit");
    idle_i = 1'b0; trig_i = '0;

    // R8 sleep
    wr(1'b0, 16'h8080);
    wr(1'b1, 16'h0055);
    exp_out(8'h55, 8'h55, 1'b1, "R8 awake baseline");
    sleep_i = 1'b1; step();
    exp_out(8'h00, 8'h00, 1'b0, "R8 sleep powers down");
    wr(1'b0, 16'h9080);
    exp_out(8'h55, 8'h55, 1'b1, "R8 keep-alive holds code");
    sleep_i = 1'b0;

    // R6 disabled
    wr(1'b0, 16'h0080);
    step();
    exp_out(8'h00, 8'h00, 1'b0, "R6 disable clears latch");
    wr(1'b1, 16'h0066);
    trig_i = 32'hFFFF_FFFF; step(); trig_i = '0;
    exp_out(8'h00, 8'h00, 1'b0, "R6 writes and events ignored");
    exp_rd(1'b1, 16'h0066, "R6 data still stored");

    // R10 warm reset, not protected
    wr(1'b0, 16'h8080);
    wr(1'b1, 16'h0044);
    exp_out(8'h44, 8'h44, 1'b1, "R10 baseline");
    warm_rst_n = 1'b0; step(); warm_rst_n = 1'b1;
    exp_out(8'h00, 8'h00, 1'b0, "R10 warm clears outputs");
    exp_rd(1'b0, 16'h0000, "R10 warm clears control");
    exp_rd(1'b1, 16'h0000, "R10 warm clears data");

    // R10 warm reset, protected
    wr(1'b0, 16'h8280);
    wr(1'b1, 16'h0033);
    warm_rst_n = 1'b0; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h00FF;
    step();
    warm_rst_n = 1'b1; wr_en = 1'b0;
    exp_out(8'h00, 8'h00, 1'b1, "R10 warm clears latch even when protected");
    exp_rd(1'b0, 16'h8280, "R10 protected control kept");
    exp_rd(1'b1, 16'h0033, "R10 protected data kept, write blocked");
    wr(1'b1, 16'h0034);
    exp_out(8'h34, 8'h34, 1'b1, "R10 operation resumes");

    // R1 power-on overrides protection
    por();
    exp_out(8'h00, 8'h00, 1'b0, "R1 power-on clears protected state");
    exp_rd(1'b0, 16'h0000, "R1 power-on control");
    exp_rd(1'b1, 16'h0000, "R1 power-on data");

    step();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule